// File: doc/BRIEF.md
# Serial Bit-Rate Tick Selector

This block produces the per-bit clock enables for a four-mode serial port. There is one lane for transmit and one for receive. Each lane picks a source tick, divides it by a mode-dependent factor and emits a single-cycle strobe at the end of each bit period. The source tick is one of three: the machine-cycle tick, the timer-1 overflow or the second timer's baud overflow. The shift registers that consume these strobes are outside this block.

The 2-bit `mode` input selects both the source and the factor for the two lanes. In the synchronous shift mode the machine-cycle tick is divided by 12. In the fixed-rate mode the machine-cycle tick is divided by 16 or 32. In the two variable-rate modes a timer overflow is divided by 16 or 32. Each lane has its own clock-select bit, so transmit and receive can run from different timers.

Each lane's divider is a two-state machine. `DV_IDLE` holds the count at zero and ignores ticks. `DV_RUN` accumulates ticks. The START transition (`DV_IDLE` to `DV_RUN`) is taken on the first clock edge at which the lane's active flag is high. The STOP transition (`DV_RUN` to `DV_IDLE`) is taken on the first clock edge at which the flag is low, and the count clears on that same edge. A tick that arrives while the count is at or above the terminal value closes the bit period. The count then returns to zero and the strobe is raised for the following cycle.

Top module: `sbr_tick_sel`

## Requirements
- R1: While `rst_n` is low, and on the first sampling after it is released, `tx_bit` and `rx_bit` are low and both dividers hold a count of zero.
- R2: With `mode`=0, both lanes count `cyc_tick` and strobe once every 12 ticks.
- R3: With `mode`=2, both lanes count `cyc_tick` and strobe every 16 ticks when `dbl_rate`=1, or every 32 ticks when `dbl_rate`=0.
- R4: With `mode`=1 or `mode`=3, each lane counts a timer tick and strobes every 16 ticks (`dbl_rate`=1) or every 32 ticks (`dbl_rate`=0).
- R5: In modes 1 and 3 the transmit lane counts `tmr2_tick` when `tx_clk_sel`=1 and `tmr1_tick` when it is 0. The receive lane does the same under `rx_clk_sel`, independently of the transmit lane.
- R6: While a lane's active flag is low, its ticks are ignored and its count is cleared. After reactivation, a full divide count is needed before the next strobe.
- R7: A tick that arrives on the same clock edge at which the active flag first rises is not counted (START takes that edge).
- R8: A strobe is high for exactly one cycle. It appears in the cycle after the clock edge that captured the completing tick.
- R9: If the factor is lowered mid-count so that the count already meets or exceeds the new terminal value, the next tick completes the bit period.
- R10: Ticks from a source that is not selected for a lane have no effect on that lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Serial mode 0..3 |
| dbl_rate | input | 1 | 1 selects divide-by-16, 0 selects divide-by-32 (modes 1..3) |
| tx_clk_sel | input | 1 | Transmit source in modes 1/3: 1 second timer, 0 timer 1 |
| rx_clk_sel | input | 1 | Receive source in modes 1/3: 1 second timer, 0 timer 1 |
| cyc_tick | input | 1 | Machine-cycle tick |
| tmr1_tick | input | 1 | Timer-1 overflow tick |
| tmr2_tick | input | 1 | Second timer baud overflow tick |
| tx_active | input | 1 | Transmit transfer in progress |
| rx_active | input | 1 | Receive transfer in progress |
| tx_bit | output | 1 | Transmit bit strobe |
| rx_bit | output | 1 | Receive bit strobe |

## Verification
A corrupted count or a stuck state shows up at the ports as a strobe on the wrong tick. It can also show up as a strobe that never comes, or one that appears while the lane is idle. The error becomes visible no later than one full divide count (at most 32 source ticks) after it occurs. A lane that remains in `DV_RUN` after its flag drops, or that counts the wrong source, produces a strobe that is preceded by no selected tick or no active cycle, and this is caught one cycle after the strobe. A START or STOP edge taken a cycle early or late shifts the first strobe by exactly one tick. The directed scenarios measure that first-strobe index directly.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [1:0] {
        SM_SHIFT  = 2'd0,
        SM_UART8  = 2'd1,
        SM_FIXED9 = 2'd2,
        SM_UART9  = 2'd3
    } ser_mode_e;

    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } dv_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sbr_src_sel.sv
module sbr_src_sel
    import sbr_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       clk_sel,
    input  logic       cyc_tick,
    input  logic       tmr1_tick,
    input  logic       tmr2_tick,
    output logic       tick
);

    ser_mode_e mode_e;
    assign mode_e = ser_mode_e'(mode);

    always_comb begin
        unique case (mode_e)
            SM_SHIFT,
            SM_FIXED9: tick = cyc_tick;
            SM_UART8,
            SM_UART9:  tick = clk_sel ? tmr2_tick : tmr1_tick;
            default:   tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/sbr_div_sel.sv
module sbr_div_sel
    import sbr_pkg::*;
#(
    parameter int DIV_SHIFT = 12,
    parameter int DIV_FAST  = 16,
    parameter int DIV_SLOW  = 32,
    parameter int CNT_W     = 5
) (
    input  logic [1:0]       mode,
    input  logic             dbl_rate,
    output logic [CNT_W-1:0] term
);

    localparam logic [CNT_W-1:0] TERM_SHIFT = CNT_W'(DIV_SHIFT - 1);
    localparam logic [CNT_W-1:0] TERM_FAST  = CNT_W'(DIV_FAST - 1);
    localparam logic [CNT_W-1:0] TERM_SLOW  = CNT_W'(DIV_SLOW - 1);

    ser_mode_e mode_e;
    assign mode_e = ser_mode_e'(mode);

    always_comb begin
        unique case (mode_e)
            SM_SHIFT:  term = TERM_SHIFT;
            SM_UART8,
            SM_FIXED9,
            SM_UART9:  term = dbl_rate ? TERM_FAST : TERM_SLOW;
            default:   term = TERM_SLOW;
        endcase
    end

endmodule

// File: rtl/sbr_bit_div.sv
module sbr_bit_div
    import sbr_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic [CNT_W-1:0] term,
    output logic             strobe
);

    dv_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state: START on active while idle, STOP on inactive while running
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DV_IDLE: if (active)  st_d = DV_RUN;
            DV_RUN:  if (!active) st_d = DV_IDLE;
            default: st_d = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DV_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            unique case (st_q)
                DV_IDLE: cnt_q <= '0;
                DV_RUN: begin
                    if (!active) begin
                        cnt_q <= '0;
                    end else if (tick) begin
                        if (cnt_q >= term) begin
                            cnt_q  <= '0;
                            strobe <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/sbr_tick_sel.sv
module sbr_tick_sel
    import sbr_pkg::*;
#(
    parameter int DIV_SHIFT = 12,
    parameter int DIV_FAST  = 16,
    parameter int DIV_SLOW  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       dbl_rate,
    input  logic       tx_clk_sel,
    input  logic       rx_clk_sel,
    input  logic       cyc_tick,
    input  logic       tmr1_tick,
    input  logic       tmr2_tick,
    input  logic       tx_active,
    input  logic       rx_active,
    output logic       tx_bit,
    output logic       rx_bit
);

    localparam int DIV_MAX = max3(DIV_SHIFT, DIV_FAST, DIV_SLOW);
    localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
    localparam int NUM_DIR = 2;

    logic [CNT_W-1:0]   term;
    logic [NUM_DIR-1:0] lane_act, lane_sel, lane_tick, lane_bit;

    assign lane_act = {rx_active, tx_active};
    assign lane_sel = {rx_clk_sel, tx_clk_sel};

    sbr_div_sel #(
        .DIV_SHIFT (DIV_SHIFT),
        .DIV_FAST  (DIV_FAST),
        .DIV_SLOW  (DIV_SLOW),
        .CNT_W     (CNT_W)
    ) u_div_sel (
        .mode     (mode),
        .dbl_rate (dbl_rate),
        .term     (term)
    );

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_lane
        sbr_src_sel u_src (
            .mode      (mode),
            .clk_sel   (lane_sel[g]),
            .cyc_tick  (cyc_tick),
            .tmr1_tick (tmr1_tick),
            .tmr2_tick (tmr2_tick),
            .tick      (lane_tick[g])
        );

        sbr_bit_div #(.CNT_W(CNT_W)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (lane_act[g]),
            .tick   (lane_tick[g]),
            .term   (term),
            .strobe (lane_bit[g])
        );
    end

    assign tx_bit = lane_bit[0];
    assign rx_bit = lane_bit[1];

endmodule

// File: rtl/sbr_tick_sel_chk.sv
module sbr_tick_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       tx_clk_sel,
    input logic       rx_clk_sel,
    input logic       cyc_tick,
    input logic       tmr1_tick,
    input logic       tmr2_tick,
    input logic       tx_active,
    input logic       rx_active,
    input logic       tx_bit,
    input logic       rx_bit
);

    logic tx_exp_tick, rx_exp_tick;
    assign tx_exp_tick = mode[0] ? (tx_clk_sel ? tmr2_tick : tmr1_tick) : cyc_tick;
    assign rx_exp_tick = mode[0] ? (rx_clk_sel ? tmr2_tick : tmr1_tick) : cyc_tick;

    // R8
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit |=> !tx_bit);
    // R8
    rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit |=> !rx_bit);
    // R6
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit |-> $past(tx_active));
    // R6
    rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit |-> $past(rx_active));
    // R10
    tx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit |-> $past(tx_exp_tick));
    // R10
    rx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit |-> $past(rx_exp_tick));

endmodule

bind sbr_tick_sel sbr_tick_sel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .tx_clk_sel (tx_clk_sel),
    .rx_clk_sel (rx_clk_sel),
    .cyc_tick   (cyc_tick),
    .tmr1_tick  (tmr1_tick),
    .tmr2_tick  (tmr2_tick),
    .tx_active  (tx_active),
    .rx_active  (rx_active),
    .tx_bit     (tx_bit),
    .rx_bit     (rx_bit)
);

// File: tb/sbr_tick_sel_tb.sv
`timescale 1ns/1ps
module sbr_tick_sel_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       dbl_rate = 1'b0;
    logic       tx_clk_sel = 1'b0;
    logic       rx_clk_sel = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       tmr1_tick = 1'b0;
    logic       tmr2_tick = 1'b0;
    logic       tx_active = 1'b0;
    logic       rx_active = 1'b0;
    logic       tx_bit, rx_bit;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [2:0] S_CYC = 3'b001;
    localparam logic [2:0] S_T1  = 3'b010;
    localparam logic [2:0] S_T2  = 3'b100;

    always #2 clk = ~clk;

    sbr_tick_sel u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dbl_rate(dbl_rate),
        .tx_clk_sel(tx_clk_sel), .rx_clk_sel(rx_clk_sel),
        .cyc_tick(cyc_tick), .tmr1_tick(tmr1_tick), .tmr2_tick(tmr2_tick),
        .tx_active(tx_active), .rx_active(rx_active),
        .tx_bit(tx_bit), .rx_bit(rx_bit)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Each tick: driven for one cycle, strobe sampled; then an empty cycle checked for a stray strobe.
    task automatic tick_run(input logic [2:0] src, input int n,
                            output int txc, output int rxc,
                            output int txf, output int rxf, output int stray);
        txc = 0; rxc = 0; txf = 0; rxf = 0; stray = 0;
        for (int i = 1; i <= n; i++) begin
            {tmr2_tick, tmr1_tick, cyc_tick} = src;
            @(negedge clk);
            if (tx_bit) begin txc++; if (txf == 0) txf = i; end
            if (rx_bit) begin rxc++; if (rxf == 0) rxf = i; end
            {tmr2_tick, tmr1_tick, cyc_tick} = 3'b000;
            @(negedge clk);
            if (tx_bit || rx_bit) stray++;
        end
    endtask

    task automatic setup(input logic [1:0] m, input logic d, input logic ts, input logic rs);
        tx_active = 1'b0; rx_active = 1'b0;
        @(negedge clk);
        mode = m; dbl_rate = d; tx_clk_sel = ts; rx_clk_sel = rs;
        tx_active = 1'b1; rx_active = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 tx_bit in reset", int'(tx_bit), 0);
        check("R1 rx_bit in reset", int'(rx_bit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_bit after reset", int'(tx_bit), 0);
        check("R1 rx_bit after reset", int'(rx_bit), 0);
    endtask

    task automatic t_mode0();
        int txc, rxc, txf, rxf, st;
        setup(2'd0, 1'b1, 1'b0, 1'b0);
        tick_run(S_CYC, 24, txc, rxc, txf, rxf, st);
        check("R2 tx count", txc, 2);
        check("R2 rx count", rxc, 2);
        check("R2 tx first", txf, 12);
        check("R2 rx first", rxf, 12);
        check("R8 single-cycle strobe", st, 0);
    endtask

    task automatic t_mode2();
        int txc, rxc, txf, rxf, st;
        setup(2'd2, 1'b1, 1'b0, 1'b0);
        tick_run(S_CYC, 32, txc, rxc, txf, rxf, st);
        check("R3 fast tx count", txc, 2);
        check("R3 fast tx first", txf, 16);
        check("R3 fast rx first", rxf, 16);
        setup(2'd2, 1'b0, 1'b0, 1'b0);
        tick_run(S_CYC, 32, txc, rxc, txf, rxf, st);
        check("R3 slow tx count", txc, 1);
        check("R3 slow rx first", rxf, 32);
        check("R8 single-cycle strobe", st, 0);
    endtask

    task automatic t_split_src();
        int txc, rxc, txf, rxf, st;
        setup(2'd1, 1'b1, 1'b1, 1'b0);
        tick_run(S_T2, 16, txc, rxc, txf, rxf, st);
        check("R5 tx on second timer", txc, 1);
        check("R10 rx ignores second timer", rxc, 0);
        tick_run(S_T1, 16, txc, rxc, txf, rxf, st);
        check("R10 tx ignores timer 1", txc, 0);
        check("R5 rx on timer 1", rxf, 16);
        tick_run(S_CYC, 32, txc, rxc, txf, rxf, st);
        check("R10 tx ignores cycle tick", txc, 0);
        check("R10 rx ignores cycle tick", rxc, 0);
    endtask

    task automatic t_mode3();
        int txc, rxc, txf, rxf, st;
        setup(2'd3, 1'b0, 1'b0, 1'b1);
        tick_run(S_T1, 32, txc, rxc, txf, rxf, st);
        check("R4 tx timer 1 slow first", txf, 32);
        check("R4 rx idle on timer 1", rxc, 0);
        tick_run(S_T2, 32, txc, rxc, txf, rxf, st);
        check("R4 rx second timer slow first", rxf, 32);
    endtask

    task automatic t_idle();
        int txc, rxc, txf, rxf, st;
        setup(2'd0, 1'b0, 1'b0, 1'b0);
        tick_run(S_CYC, 5, txc, rxc, txf, rxf, st);
        tx_active = 1'b0; rx_active = 1'b0;
        @(negedge clk);
        tick_run(S_CYC, 20, txc, rxc, txf, rxf, st);
        check("R6 no tx strobe while idle", txc, 0);
        check("R6 no rx strobe while idle", rxc, 0);
        tx_active = 1'b1; rx_active = 1'b1;
        @(negedge clk);
        tick_run(S_CYC, 12, txc, rxc, txf, rxf, st);
        check("R6 tx full count after idle", txf, 12);
        check("R6 rx full count after idle", rxf, 12);
    endtask

    task automatic t_start_edge();
        int txc, rxc, txf, rxf, st;
        tx_active = 1'b0; rx_active = 1'b0; mode = 2'd0;
        @(negedge clk);
        tx_active = 1'b1; cyc_tick = 1'b1;
        @(negedge clk);
        cyc_tick = 1'b0;
        @(negedge clk);
        tick_run(S_CYC, 12, txc, rxc, txf, rxf, st);
        check("R7 start-edge tick not counted", txf, 12);
        check("R6 rx stays idle", rxc, 0);
    endtask

    task automatic t_shrink();
        int txc, rxc, txf, rxf, st;
        setup(2'd2, 1'b0, 1'b0, 1'b0);
        tick_run(S_CYC, 20, txc, rxc, txf, rxf, st);
        check("R9 no strobe before shrink", txc, 0);
        dbl_rate = 1'b1;
        tick_run(S_CYC, 1, txc, rxc, txf, rxf, st);
        check("R9 tx completes on next tick", txc, 1);
        check("R9 rx completes on next tick", rxc, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_mode0();
        t_mode2();
        t_split_src();
        t_mode3();
        t_idle();
        t_start_edge();
        t_shrink();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule